// File: doc/BRIEF.md
# Context/Decision Pair Sequencer

This block decouples a column-parallel context modeler from an arithmetic coder that can take only one context/decision pair per clock. In each cycle the modeler may present a group of up to ten slots. Each slot carries a 5-bit context, a decision bit and a valid flag. The sequencer discards the empty slots and packs the occupied ones into a circular buffer. It then hands the pairs to the coder one at a time over a valid/ready handshake, in exactly the order the modeler produced them.

The modeler side is governed at group granularity. The block accepts a group only when the buffer can hold a full group, so a group is never partly taken. A flush flag on the last group of a code block arms a done indication, and that indication rises once every buffered pair has left. A synchronous reset empties the buffer at once.

Top module: `cxd_sequencer`

## Requirements
- R1: After reset, outValid is 0, done is 0 and inReady is 1.
- R2: Slot i carries its context on inCtx[5*i+4:5*i] and its decision on inDec[i]. A pair leaves on outCtx (context) and outDec (decision) with both fields unchanged.
- R3: Within one accepted group, slots whose inSlotValid bit is 0 produce no output. The valid slots are emitted in increasing slot index.
- R4: Pairs from successive accepted groups are emitted in group order, including when the buffer positions wrap around.
- R5: At most one pair leaves per cycle. The head pair advances only on a cycle with outValid=1 and outReady=1. While outReady is 0, outValid, outCtx and outDec hold their values.
- R6: inReady is 1 exactly when the buffer holds no more than DEPTH-SLOTS pairs. A group presented while inReady is 0 is ignored and adds no pairs.
- R7: The buffer never holds more than DEPTH pairs, and outValid is 1 exactly when it holds at least one pair.
- R8: A pair accepted into an empty buffer is presented on the output in the cycle right after the accepting clock edge.
- R9: After a group with inFlush=1 is accepted, done is 1 whenever the buffer is empty. done returns to 0 when a later group without inFlush is accepted, and done is never 1 while outValid is 1.
- R10: A synchronous reset while pairs are held discards them: outValid goes to 0, inReady to 1 and done to 0.
- R11: An accepted group with no valid slot adds nothing to the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A group is presented |
| inSlotValid | input | SLOTS | Per-slot occupancy flags |
| inCtx | input | 5*SLOTS | Per-slot 5-bit contexts, slot i at bits 5i+4..5i |
| inDec | input | SLOTS | Per-slot decision bits |
| inFlush | input | 1 | Presented group is the last one of a code block |
| inReady | output | 1 | Room for a full group |
| outValid | output | 1 | A pair is presented to the coder |
| outCtx | output | 5 | Context of the head pair |
| outDec | output | 1 | Decision of the head pair |
| outReady | input | 1 | Coder takes the pair this cycle |
| done | output | 1 | Flushed code block fully drained |

## Verification
An accepted group is visible on the outputs at the first sample after its accepting edge: outValid, inReady and done all move one edge after the handshake that causes them. The bench therefore drives on falling edges and samples at the next falling edge. During a drain with outReady held high, a new pair is expected at every falling-edge sample, and the pair sampled there is the one the next rising edge consumes. The backpressure limit is checked by removing pairs one at a time. inReady must stay low at an occupancy of DEPTH-SLOTS+1 and must rise at the sample that follows the pop reaching DEPTH-SLOTS.

// File: rtl/cxd_pkg.sv
package cxd_pkg;
  localparam int CTX_W  = 5;
  localparam int PAIR_W = CTX_W + 1;

  typedef struct packed {
    logic [CTX_W-1:0] ctx;
    logic             dec;
  } cxd_pair_t;

  typedef struct packed {
    logic push;
    logic pop;
  } cxd_strobe_t;
endpackage

// File: rtl/cxd_seq_datapath.sv
module cxd_seq_datapath
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  cxd_strobe_t            strobe,
  input  logic [AW-1:0]          wrBase,
  input  logic [AW-1:0]          rdAddr,
  input  logic [SLOTS-1:0]       slotValid,
  input  logic [CTX_W*SLOTS-1:0] slotCtx,
  input  logic [SLOTS-1:0]       slotDec,
  output logic [CW-1:0]          groupCount,
  output logic [CTX_W-1:0]       outCtx,
  output logic                   outDec
);
  cxd_pair_t slotPair [SLOTS];
  logic [CW-1:0] slotOffset [SLOTS];
  logic [CW-1:0] runCount;
  cxd_pair_t store [DEPTH];
  cxd_pair_t headPair;

  // unpack the flat group into per-slot pairs
  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign slotPair[s].ctx = slotCtx[CTX_W*s +: CTX_W];
    assign slotPair[s].dec = slotDec[s];
  end

  // prefix count of valid slots below each index gives the packed position
  always_comb begin
    runCount = '0;
    for (int s = 0; s < SLOTS; s++) begin
      slotOffset[s] = runCount;
      runCount = runCount + CW'(slotValid[s]);
    end
  end
  assign groupCount = runCount;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slotValid[s]) begin
          store[AW'(wrBase + AW'(slotOffset[s]))] <= slotPair[s];
        end
      end
    end
  end

  assign headPair = store[rdAddr];
  assign outCtx   = headPair.ctx;
  assign outDec   = headPair.dec;
endmodule

// File: rtl/cxd_seq_ctrl.sv
module cxd_seq_ctrl
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1,
  localparam int CW = $clog2(SLOTS + 1),
  localparam logic [PW-1:0] ROOM_LIMIT = PW'(DEPTH - SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          inFlush,
  input  logic          outReady,
  input  logic [CW-1:0] groupCount,
  output logic          inReady,
  output logic          outValid,
  output logic          done,
  output cxd_strobe_t   strobe,
  output logic [AW-1:0] wrBase,
  output logic [AW-1:0] rdAddr
);
  logic [PW-1:0] wrPtr, rdPtr, fill;
  logic flushArmed;

  assign fill     = wrPtr - rdPtr;
  assign inReady  = (fill <= ROOM_LIMIT);
  assign outValid = (fill != '0);
  assign strobe.push = inValid && inReady;
  assign strobe.pop  = outValid && outReady;
  assign wrBase = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];
  assign done   = flushArmed && !outValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      flushArmed <= 1'b0;
    end else begin
      if (strobe.push) begin
        wrPtr      <= wrPtr + PW'(groupCount);
        flushArmed <= inFlush;
      end
      if (strobe.pop) begin
        rdPtr <= rdPtr + PW'(1);
      end
    end
  end
endmodule

// File: rtl/cxd_sequencer.sv
module cxd_sequencer
  import cxd_pkg::*;
#(
  parameter int SLOTS = 10,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic [SLOTS-1:0]       inSlotValid,
  input  logic [CTX_W*SLOTS-1:0] inCtx,
  input  logic [SLOTS-1:0]       inDec,
  input  logic                   inFlush,
  output logic                   inReady,
  output logic                   outValid,
  output logic [CTX_W-1:0]       outCtx,
  output logic                   outDec,
  input  logic                   outReady,
  output logic                   done
);
  cxd_strobe_t   strobe;
  logic [AW-1:0] wrBase, rdAddr;
  logic [CW-1:0] groupCount;

  cxd_seq_ctrl #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inFlush(inFlush),
    .outReady(outReady), .groupCount(groupCount), .inReady(inReady),
    .outValid(outValid), .done(done), .strobe(strobe),
    .wrBase(wrBase), .rdAddr(rdAddr)
  );

  cxd_seq_datapath #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .strobe(strobe), .wrBase(wrBase), .rdAddr(rdAddr),
    .slotValid(inSlotValid), .slotCtx(inCtx), .slotDec(inDec),
    .groupCount(groupCount), .outCtx(outCtx), .outDec(outDec)
  );
endmodule

// File: rtl/cxd_sequencer_chk.sv
module cxd_sequencer_chk #(
  parameter int SLOTS = 10,
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [SLOTS-1:0] inSlotValid,
  input logic             inReady,
  input logic             outValid,
  input logic [4:0]       outCtx,
  input logic             outDec,
  input logic             outReady,
  input logic             done
);
  logic [PW-1:0] shadowFill;

  always_ff @(posedge clk) begin
    if (rst) shadowFill <= '0;
    else shadowFill <= shadowFill
      + ((inValid && inReady) ? PW'($countones(inSlotValid)) : PW'(0))
      - ((outValid && outReady) ? PW'(1) : PW'(0));
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!outValid && !done && inReady));
  // R5
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outCtx) && $stable(outDec)));
  // R6
  group_room_chk: assert property (@(posedge clk) disable iff (rst)
    inReady == (shadowFill <= PW'(DEPTH - SLOTS)));
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (shadowFill <= PW'(DEPTH)) && (outValid == (shadowFill != '0)));
  // R9
  done_when_empty_chk: assert property (@(posedge clk) disable iff (rst) done |-> !outValid);
endmodule

bind cxd_sequencer cxd_sequencer_chk #(.SLOTS(SLOTS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inSlotValid(inSlotValid),
  .inReady(inReady), .outValid(outValid), .outCtx(outCtx), .outDec(outDec),
  .outReady(outReady), .done(done)
);

// File: tb/tb_cxd_sequencer.sv
module tb_cxd_sequencer;
  localparam int SLOTS = 10;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [SLOTS-1:0] inSlotValid = '0;
  logic [5*SLOTS-1:0] inCtx = '0;
  logic [SLOTS-1:0] inDec = '0;
  logic inFlush = 1'b0;
  logic inReady, outValid, outDec, done;
  logic [4:0] outCtx;
  logic outReady = 1'b0;

  int checks = 0;
  int failures = 0;
  int tagN = 0;
  bit finished = 0;
  logic [5:0] expQ [$];

  always #10 clk = ~clk;

  cxd_sequencer #(.SLOTS(SLOTS), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSlotValid(inSlotValid),
    .inCtx(inCtx), .inDec(inDec), .inFlush(inFlush), .inReady(inReady),
    .outValid(outValid), .outCtx(outCtx), .outDec(outDec),
    .outReady(outReady), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // present one group; expected pairs are queued only if it is taken
  task automatic pushGroup(input logic [SLOTS-1:0] mask, input bit flush);
    while (!inReady) @(negedge clk);
    inValid = 1'b1;
    inSlotValid = mask;
    inFlush = flush;
    for (int s = 0; s < SLOTS; s++) begin
      logic [4:0] c;
      logic d;
      c = 5'((tagN * 7 + 3) % 32);
      d = tagN[0] ^ tagN[3];
      inCtx[5*s +: 5] = c;
      inDec[s] = d;
      if (mask[s]) expQ.push_back({c, d});
      tagN++;
    end
    @(negedge clk);
    inValid = 1'b0;
    inFlush = 1'b0;
  endtask

  task automatic drainAll(input string req);
    outReady = 1'b1;
    while (expQ.size() > 0) begin
      logic [5:0] e;
      e = expQ.pop_front();
      chk(outValid == 1'b1, req, int'(outValid), 1);
      chk({outCtx, outDec} == e, req, int'({outCtx, outDec}), int'(e));
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(outValid == 1'b0, req, int'(outValid), 0);
  endtask

  task automatic t_reset();
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(inReady == 1'b1, "R1", int'(inReady), 1);
  endtask

  task automatic t_compact();
    pushGroup(10'b1010010110, 1'b0);
    // R8: visible at the first sample after acceptance
    chk(outValid == 1'b1, "R8", int'(outValid), 1);
    drainAll("R3 R2");
  endtask

  task automatic t_order();
    pushGroup(10'b1111111111, 1'b0);
    pushGroup(10'b0000001111, 1'b0);
    pushGroup(10'b1100110011, 1'b0);
    drainAll("R4");
    // second round crosses the buffer wrap point
    pushGroup(10'b1111111111, 1'b0);
    pushGroup(10'b1111100000, 1'b0);
    pushGroup(10'b0101010101, 1'b0);
    drainAll("R4 R5");
  endtask

  task automatic t_stall();
    logic [5:0] head;
    pushGroup(10'b0000000111, 1'b0);
    head = {outCtx, outDec};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(outValid == 1'b1 && {outCtx, outDec} == expQ[0], "R5",
          int'({outCtx, outDec}), int'(expQ[0]));
    end
    chk(head == expQ[0], "R5", int'(head), int'(expQ[0]));
    drainAll("R5");
  endtask

  task automatic t_backpressure();
    pushGroup(10'b1111111111, 1'b0);
    pushGroup(10'b1111111111, 1'b0);
    chk(inReady == 1'b1, "R6", int'(inReady), 1);
    pushGroup(10'b1111111111, 1'b0);
    chk(inReady == 1'b0, "R6", int'(inReady), 0);
    // a group offered now must be dropped
    inValid = 1'b1;
    inSlotValid = '1;
    @(negedge clk);
    inValid = 1'b0;
    for (int k = 0; k < 8; k++) begin
      outReady = 1'b1;
      chk({outCtx, outDec} == expQ[0], "R6", int'({outCtx, outDec}), int'(expQ[0]));
      void'(expQ.pop_front());
      @(negedge clk);
      outReady = 1'b0;
      if (k < 7) chk(inReady == 1'b0, "R6", int'(inReady), 0);
      else chk(inReady == 1'b1, "R6", int'(inReady), 1);
    end
    drainAll("R6 R7");
  endtask

  task automatic t_empty_group();
    pushGroup('0, 1'b0);
    chk(outValid == 1'b0, "R11", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b0, "R11", int'(outValid), 0);
  endtask

  task automatic t_flush();
    pushGroup(10'b0000010101, 1'b1);
    chk(done == 1'b0, "R9", int'(done), 0);
    drainAll("R9");
    chk(done == 1'b1, "R9", int'(done), 1);
    @(negedge clk);
    chk(done == 1'b1, "R9", int'(done), 1);
    pushGroup(10'b0000000011, 1'b0);
    chk(done == 1'b0, "R9", int'(done), 0);
    drainAll("R9");
    chk(done == 1'b0, "R9", int'(done), 0);
  endtask

  task automatic t_reset_mid();
    pushGroup(10'b1111111111, 1'b1);
    pushGroup(10'b1111111111, 1'b0);
    pushGroup(10'b1111111111, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expQ.delete();
    chk(outValid == 1'b0, "R10", int'(outValid), 0);
    chk(inReady == 1'b1, "R10", int'(inReady), 1);
    chk(done == 1'b0, "R10", int'(done), 0);
    pushGroup(10'b1000000001, 1'b0);
    drainAll("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_compact();
    t_order();
    t_stall();
    t_backpressure();
    t_empty_group();
    t_flush();
    t_reset_mid();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule